// File: doc/BRIEF.md
# Compact 16-bit Harvard processor core

A single-issue, multi-cycle 16-bit processor with a synchronous instruction ROM port and a separate data RAM port. Sixteen 16-bit registers form the register file. Entry 0 always reads as zero and entry 15 is the program counter, so any instruction that writes entry 15 is a jump. The core has no branch opcodes. A one-word prefix instead makes the following instruction depend on the status flags, and a squashed instruction has no effect.

Every instruction is a 16-bit word. Some instructions carry a second word that holds a 16-bit constant or address. Arithmetic, shifts and logic operate on registers, a load-immediate writes a constant, and loads and stores reach data memory in one of two ways: through a register that is post-adjusted by a small signed step, or through an absolute address. Multiply, divide, interrupts and byte addressing are not provided.

Top module: `hr16_core`

## Requirements
- R1: While `rstN` is low, every register, the flags (Z,N,C,V) and the prefix state are cleared, `imemAddr` is 0 and neither `dmemWe` nor `dmemRe` is asserted. Execution starts at address 0.
- R2: Register 0 reads as 0 in every operand position, and writes to it are discarded.
- R3: Register 15 is the program counter. As an operand it reads as the address of the word after the current instruction, including that instruction's second word if it has one. Writing it makes execution continue at the written address.
- R4: Word fields are opcode[15:12], d[11:8], a[7:4] and b[3:0]. Opcodes: 0 ADD, 1 SUB, 2 SHL, 3 SHR (d=a op b); 4 ADDI, 5 SUBI, 6 SHLI, 7 SHRI (d=a op b, with b taken as a zero-extended 4-bit constant); 8 AND, 9 OR, 10 XOR; 11 LDI; 12 LD; 13 ST; 14 LDA; 15 with a=0 STA, with a=1 PRED. Opcode 15 with any other a is a no-op.
- R5: The shift amount is the low 4 bits of the second operand. SHL shifts left and SHR is a logical right shift, both filling with zeros. All results are taken modulo 2^16.
- R6: ADD, SUB and the shifts, in both their forms, set Z (result zero) and N (result bit 15). ADD sets C to the carry out and V to signed overflow. SUB sets C when a >= b unsigned and V on signed overflow. A shift sets C to the last bit shifted out (0 for a shift of 0) and clears V.
- R7: AND, OR and XOR set Z and N and clear C and V. LDI, LD, ST, LDA, STA and PRED leave the flags unchanged.
- R8: LDI (d=word 2), LDA (d=mem[word 2]) and STA (mem[word 2]=register d) are two words long, and the program counter moves past both words.
- R9: LD sets d=mem[a]. ST sets mem[a]=d. Both then set a=a+sign-extended b. When LD has d equal to a, the loaded value is the one that remains.
- R10: PRED's b field selects a condition: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 never.
- R11: When the condition is false, exactly the next instruction (jumps included) is squashed: no register, flag or memory write. The program counter still moves past all of its words, and the instruction after it runs normally.
- R12: Timing counted in cycles from the start of the fetch: one-word register operations, ST and PRED take 3 cycles; LDI and STA take 4; LD takes 4; LDA takes 5. Stores drive `dmemWe` in their last cycle. Loads drive `dmemRe` one cycle before their last cycle, and the RAM returns the data on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | 16 | Instruction ROM word address (current program counter) |
| imemData | input | 16 | ROM word, registered by the ROM from the previous cycle's address |
| dmemAddr | output | 16 | Data RAM word address |
| dmemWrData | output | 16 | Data RAM write value |
| dmemWe | output | 1 | Data RAM write strobe |
| dmemRe | output | 1 | Data RAM read strobe |
| dmemRdData | input | 16 | RAM read value, registered by the RAM from the previous cycle's strobe |

## Verification
Register results can only be observed through memory, so each test program ends by storing what it computed, and the checks read the RAM model only after the completion marker store has been seen. Flag results are due on the cycle after the arithmetic instruction that sets them. They are observed by predicating load-immediates on Z, N, C and V and storing the results, so a flag error shows up as a wrong stored word. The cycle counts in R12 are checked from strobe timing. The bench samples at falling edges and records the cycle index of the first `dmemRe` and the first `dmemWe` after reset. Those indices must equal 2 and 7 for a load followed by an absolute store, and 6 for a register operation followed by an absolute store.

// File: rtl/hr16_pkg.sv
package hr16_pkg;
  localparam int XW      = 16;
  localparam int NREG    = 16;
  localparam int RW      = $clog2(NREG);
  localparam int SHW     = $clog2(XW);
  localparam int IMMW    = 4;
  localparam int ZERO_IDX = 0;
  localparam int PC_IDX  = NREG - 1;

  localparam logic [3:0] OP_LDI = 4'd11;
  localparam logic [3:0] OP_LD  = 4'd12;
  localparam logic [3:0] OP_ST  = 4'd13;
  localparam logic [3:0] OP_LDA = 4'd14;
  localparam logic [3:0] OP_SYS = 4'd15;
  localparam logic [3:0] SYS_STA  = 4'd0;
  localparam logic [3:0] SYS_PRED = 4'd1;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SHL, ALU_SHR, ALU_AND, ALU_OR, ALU_XOR
  } alu_op_e;

  typedef enum logic [1:0] { WB_ALU, WB_IMM, WB_MEM, WB_ADDR } wb_sel_e;

  typedef struct packed {
    logic z, n, c, v;
  } flags_t;

  typedef struct packed {
    logic            pcInc;
    logic            regWe;
    logic [RW-1:0]   wrIdx;
    wb_sel_e         wbSel;
    logic            flagWe;
    alu_op_e         aluOp;
    logic            useImm;
    logic [RW-1:0]   aIdx;
    logic [RW-1:0]   bIdx;
    logic [IMMW-1:0] imm4;
    logic [XW-1:0]   imm16;
    logic            absAddr;
    logic            memRe;
    logic            memWe;
  } strobes_t;

  function automatic logic condHolds(input logic [3:0] cc, input flags_t f);
    case (cc)
      4'd0:  return f.z;
      4'd1:  return !f.z;
      4'd2:  return f.c;
      4'd3:  return !f.c;
      4'd4:  return f.n;
      4'd5:  return !f.n;
      4'd6:  return f.v;
      4'd7:  return !f.v;
      4'd8:  return f.c && !f.z;
      4'd9:  return !f.c || f.z;
      4'd10: return f.n == f.v;
      4'd11: return f.n != f.v;
      4'd12: return !f.z && (f.n == f.v);
      4'd13: return f.z || (f.n != f.v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic twoWord(input logic [XW-1:0] w);
    return (w[15:12] == OP_LDI) || (w[15:12] == OP_LDA) ||
           (w[15:12] == OP_SYS && w[7:4] == SYS_STA);
  endfunction
endpackage

// File: rtl/hr16_ctrl.sv
module hr16_ctrl
  import hr16_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [XW-1:0] imemData,
  input  flags_t        flags,
  output strobes_t      st
);
  typedef enum logic [2:0] { S_FETCH, S_DECODE, S_IMM, S_EXEC, S_LOADWB } state_e;

  state_e        state;
  logic [XW-1:0] ir, immReg;
  logic          pend;
  logic [3:0]    pendCc;

  logic [3:0] op;
  logic       predOk, isPred, isLoad;
  assign op     = ir[15:12];
  assign predOk = !pend || condHolds(pendCc, flags);
  assign isPred = (op == OP_SYS) && (ir[7:4] == SYS_PRED);
  assign isLoad = (op == OP_LD) || (op == OP_LDA);

  always_comb begin
    st        = '0;
    st.aIdx   = ir[7:4];
    st.bIdx   = ir[3:0];
    st.imm4   = ir[3:0];
    st.imm16  = immReg;
    st.wrIdx  = ir[11:8];
    st.aluOp  = alu_op_e'({op[3], op[1:0]});
    st.useImm = !op[3] && op[2];
    st.wbSel  = WB_ALU;
    case (state)
      S_FETCH:  st.pcInc = 1'b1;
      S_DECODE: st.pcInc = twoWord(imemData);
      S_EXEC: if (predOk) begin
        if (op <= 4'd10) begin
          st.regWe  = 1'b1;
          st.flagWe = 1'b1;
        end else begin
          case (op)
            OP_LDI: begin st.regWe = 1'b1; st.wbSel = WB_IMM; end
            OP_LD:  begin
              st.memRe = 1'b1; st.regWe = 1'b1;
              st.wbSel = WB_ADDR; st.wrIdx = ir[7:4];
            end
            OP_ST:  begin
              st.memWe = 1'b1; st.bIdx = ir[11:8]; st.regWe = 1'b1;
              st.wbSel = WB_ADDR; st.wrIdx = ir[7:4];
            end
            OP_LDA: begin st.memRe = 1'b1; st.absAddr = 1'b1; end
            OP_SYS: if (ir[7:4] == SYS_STA) begin
              st.memWe = 1'b1; st.absAddr = 1'b1; st.bIdx = ir[11:8];
            end
            default: ;
          endcase
        end
      end
      S_LOADWB: begin st.regWe = 1'b1; st.wbSel = WB_MEM; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_FETCH;
      ir     <= '0;
      immReg <= '0;
      pend   <= 1'b0;
      pendCc <= '0;
    end else begin
      case (state)
        S_FETCH:  state <= S_DECODE;
        S_DECODE: begin
          ir    <= imemData;
          state <= twoWord(imemData) ? S_IMM : S_EXEC;
        end
        S_IMM: begin
          immReg <= imemData;
          state  <= S_EXEC;
        end
        S_EXEC: begin
          pend   <= predOk && isPred;
          pendCc <= ir[3:0];
          state  <= (predOk && isLoad) ? S_LOADWB : S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  // R11: a squashed instruction leaves every write strobe low
  a_r11_squash_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_EXEC && !predOk) |-> !(st.regWe || st.flagWe || st.memWe || st.memRe));
  // R12: one memory strobe at a time
  a_r12_mem_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(st.memRe && st.memWe));
  // R8: the second word is captured only right after decode
  a_r8_imm_after_decode: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IMM) |-> ($past(state) == S_DECODE));
  // R9: a load write-back always follows a read strobe
  a_r9_wb_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_LOADWB) |-> $past(st.memRe));
endmodule

// File: rtl/hr16_dpath.sv
module hr16_dpath
  import hr16_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      st,
  input  logic [XW-1:0] dmemRdData,
  output logic [XW-1:0] imemAddr,
  output logic [XW-1:0] dmemAddr,
  output logic [XW-1:0] dmemWrData,
  output flags_t        flags
);
  localparam int MSB = XW - 1;

  logic [XW-1:0] regs [NREG];
  logic [XW-1:0] opA, regB, opB, res, addrNext, wbData;
  logic [SHW-1:0] amt;
  logic [XW:0]     sum;
  logic [2*XW-1:0] shl, shr;
  logic cOut, vOut;

  assign opA  = (st.aIdx == RW'(ZERO_IDX)) ? '0 : regs[st.aIdx];
  assign regB = (st.bIdx == RW'(ZERO_IDX)) ? '0 : regs[st.bIdx];
  assign opB  = st.useImm ? XW'(st.imm4) : regB;
  assign amt  = opB[SHW-1:0];
  assign addrNext = opA + {{(XW-IMMW){st.imm4[IMMW-1]}}, st.imm4};

  always_comb begin
    res  = '0;
    cOut = 1'b0;
    vOut = 1'b0;
    sum  = '0;
    shl  = '0;
    shr  = '0;
    case (st.aluOp)
      ALU_ADD: begin
        sum  = {1'b0, opA} + {1'b0, opB};
        res  = sum[XW-1:0];
        cOut = sum[XW];
        vOut = (opA[MSB] == opB[MSB]) && (res[MSB] != opA[MSB]);
      end
      ALU_SUB: begin
        res  = opA - opB;
        cOut = (opA >= opB);
        vOut = (opA[MSB] != opB[MSB]) && (res[MSB] != opA[MSB]);
      end
      ALU_SHL: begin
        shl  = {{XW{1'b0}}, opA} << amt;
        res  = shl[XW-1:0];
        cOut = shl[XW];
      end
      ALU_SHR: begin
        shr  = {opA, {XW{1'b0}}} >> amt;
        res  = shr[2*XW-1:XW];
        cOut = shr[XW-1];
      end
      ALU_AND: res = opA & opB;
      ALU_OR:  res = opA | opB;
      ALU_XOR: res = opA ^ opB;
      default: res = '0;
    endcase
  end

  always_comb begin
    case (st.wbSel)
      WB_IMM:  wbData = st.imm16;
      WB_MEM:  wbData = dmemRdData;
      WB_ADDR: wbData = addrNext;
      default: wbData = res;
    endcase
  end

  assign imemAddr   = regs[PC_IDX];
  assign dmemAddr   = st.absAddr ? st.imm16 : opA;
  assign dmemWrData = regB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      flags <= '0;
    end else begin
      if (st.pcInc)
        regs[PC_IDX] <= regs[PC_IDX] + 1'b1;
      else if (st.regWe && st.wrIdx != RW'(ZERO_IDX))
        regs[st.wrIdx] <= wbData;
      if (st.flagWe)
        flags <= '{z: (res == '0), n: res[MSB], c: cOut, v: vOut};
    end
  end

  // R2: the zero entry never holds anything else
  a_r2_zero_reg: assert property (@(posedge clk) disable iff (!rstN)
    regs[ZERO_IDX] == '0);
  // R3: a fetch step moves the program counter by exactly one word
  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    st.pcInc |=> (regs[PC_IDX] == $past(regs[PC_IDX]) + 1'b1));
  // R7: flags only move when the control asks for it
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !st.flagWe |=> $stable(flags));
endmodule

// File: rtl/hr16_core.sv
module hr16_core
  import hr16_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  output logic [XW-1:0] imemAddr,
  input  logic [XW-1:0] imemData,
  output logic [XW-1:0] dmemAddr,
  output logic [XW-1:0] dmemWrData,
  output logic          dmemWe,
  output logic          dmemRe,
  input  logic [XW-1:0] dmemRdData
);
  strobes_t st;
  flags_t   flags;

  hr16_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .imemData(imemData), .flags(flags), .st(st)
  );

  hr16_dpath uDpath (
    .clk(clk), .rstN(rstN), .st(st), .dmemRdData(dmemRdData),
    .imemAddr(imemAddr), .dmemAddr(dmemAddr), .dmemWrData(dmemWrData),
    .flags(flags)
  );

  assign dmemWe = st.memWe;
  assign dmemRe = st.memRe;

  // R1: no memory strobe can leak out while reset is held
  a_r1_reset_quiet: assert property (@(negedge clk) !rstN |-> !(dmemWe || dmemRe));
endmodule

// File: tb/sim_hr16_core.sv
`timescale 1ns/1ps
module sim_hr16_core;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] imemAddr, imemData, dmemAddr, dmemWrData, dmemRdData;
  logic        dmemWe, dmemRe;

  logic [15:0] rom [256];
  logic [15:0] ram [256];
  int nChecks = 0, nErrors = 0;
  int pcw, cyc, weCyc, reCyc;
  bit done;

  always #2 clk = ~clk;

  hr16_core u0 (
    .clk(clk), .rstN(rstN), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrData(dmemWrData), .dmemWe(dmemWe),
    .dmemRe(dmemRe), .dmemRdData(dmemRdData)
  );

  always @(posedge clk) begin
    imemData <= rom[imemAddr[7:0]];
    if (dmemRe) dmemRdData <= ram[dmemAddr[7:0]];
    if (dmemWe) ram[dmemAddr[7:0]] <= dmemWrData;
    if (!rstN) cyc <= 0; else cyc <= cyc + 1;
  end

  always @(negedge clk) if (rstN) begin
    if (dmemWe && dmemAddr == 16'h00FF) done = 1'b1;
    if (dmemWe && weCyc < 0) weCyc = cyc;
    if (dmemRe && reCyc < 0) reCyc = cyc;
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int d, input int a, input int b);
    return {4'(op), 4'(d), 4'(a), 4'(b)};
  endfunction

  task automatic newProg();
    for (int i = 0; i < 256; i++) begin rom[i] = 16'h0; ram[i] = 16'h0; end
    pcw = 0;
  endtask
  task automatic emit(input logic [15:0] w); rom[pcw] = w; pcw++; endtask
  task automatic ldi(input int d, input logic [15:0] v); emit(enc(11, d, 0, 0)); emit(v); endtask
  task automatic sta(input int r, input logic [15:0] a); emit(enc(15, r, 0, 0)); emit(a); endtask
  task automatic pred(input int cc); emit(enc(15, 0, 1, cc)); endtask
  task automatic endProg(); sta(0, 16'h00FF); ldi(15, 16'(pcw)); endtask

  task automatic runProg();
    rstN = 1'b0; done = 1'b0; weCyc = -1; reCyc = -1;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    if (!done) chk("R12 program did not finish", 0, 1);
    @(negedge clk);
  endtask

  // model: {z,n,c,v,result}
  function automatic logic [19:0] model(input int op, input logic [15:0] a, input logic [15:0] b);
    logic [15:0] r; logic c, v; logic [16:0] s17; int sh;
    c = 0; v = 0; sh = b & 15;
    case (op)
      0: begin s17 = a + b; r = s17[15:0]; c = s17[16];
               v = (a[15] == b[15]) && (r[15] != a[15]); end
      1: begin r = a - b; c = (a >= b); v = (a[15] != b[15]) && (r[15] != a[15]); end
      2: begin r = 16'(a << sh); c = (sh != 0) ? ((a >> (16 - sh)) & 1) : 0; end
      3: begin r = a >> sh; c = (sh != 0) ? ((a >> (sh - 1)) & 1) : 0; end
      8: r = a & b;
      9: r = a | b;
      default: r = a ^ b;
    endcase
    return {(r == 0), r[15], c, v, r};
  endfunction

  function automatic bit condExp(input int cc, input logic [3:0] f);
    logic z, n, c, v; {z, n, c, v} = f;
    case (cc)
      0: return z;  1: return !z;  2: return c;  3: return !c;
      4: return n;  5: return !n;  6: return v;  7: return !v;
      8: return c & !z;  9: return !c | z;  10: return n == v;  11: return n != v;
      12: return !z & (n == v);  13: return z | (n != v);  14: return 1; default: return 0;
    endcase
  endfunction

  // one ALU operation, result and the four flags stored to 0x80..0x84
  task automatic aluRun(input int op, input logic [15:0] a, input logic [15:0] b, input bit imm);
    logic [19:0] e;
    newProg();
    emit(enc(1, 8, 0, 0));           // 0-0: leaves Z=1 and C=1 before the operation
    ldi(1, a);
    if (imm) emit(enc(op + 4, 3, 1, b & 15));
    else begin ldi(2, b); emit(enc(op, 3, 1, 2)); end
    sta(3, 16'h80);
    pred(0); ldi(4, 1); pred(4); ldi(5, 1); pred(2); ldi(6, 1); pred(6); ldi(7, 1);
    sta(4, 16'h81); sta(5, 16'h82); sta(6, 16'h83); sta(7, 16'h84);
    endProg();
    runProg();
    e = model(op, a, imm ? 16'(b & 15) : b);
    if (op < 4) begin
      chk(imm ? "R6 imm result" : "R5 result", ram[8'h80], e[15:0]);
      chk("R6 flag Z", ram[8'h81], e[19]); chk("R6 flag N", ram[8'h82], e[18]);
      chk("R6 flag C", ram[8'h83], e[17]); chk("R6 flag V", ram[8'h84], e[16]);
    end else begin
      chk("R4 logic result", ram[8'h80], e[15:0]);
      chk("R7 logic Z", ram[8'h81], e[19]); chk("R7 logic N", ram[8'h82], e[18]);
      chk("R7 logic clears C", ram[8'h83], 0); chk("R7 logic clears V", ram[8'h84], 0);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    chk("R12 watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin : main
    logic [15:0] vals [8];
    int ops [7];
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'h8001};
    ops  = '{0, 1, 2, 3, 8, 9, 10};

    // R1: reset state at the ports
    newProg();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 imemAddr in reset", imemAddr, 0);
    chk("R1 dmemWe in reset", dmemWe, 0);
    chk("R1 dmemRe in reset", dmemRe, 0);

    // R5 R6 R7: register-register sweep
    foreach (ops[k]) foreach (vals[i]) foreach (vals[j])
      aluRun(ops[k], vals[i], vals[j], 1'b0);
    // R6: immediate forms over every 4-bit constant
    for (int k = 0; k < 4; k++) foreach (vals[i])
      for (int m = 0; m < 16; m++) aluRun(k, vals[i], 16'(m), 1'b1);

    // R2 R3: zero register, reading and writing the program counter
    newProg();
    ldi(0, 16'h1234);                // 0,1
    sta(0, 16'h90);                  // 2,3
    emit(enc(9, 1, 15, 0));          // 4: r1 = 5
    sta(1, 16'h91);                  // 5,6
    sta(15, 16'h92);                 // 7,8: stores 9
    ldi(15, 16'd14);                 // 9,10: jump
    ldi(3, 16'h0BAD);                // 11,12 skipped
    emit(16'h0);                     // 13
    sta(3, 16'h93);                  // 14,15
    emit(enc(4, 15, 15, 2));         // 16: pc 17 + 2 = 19
    ldi(7, 16'hDEAD);                // 17,18 skipped
    sta(7, 16'h94);                  // 19
    endProg();
    runProg();
    chk("R2 write to r0 discarded", ram[8'h90], 0);
    chk("R3 pc reads next address", ram[8'h91], 5);
    chk("R3 pc past two-word store", ram[8'h92], 9);
    chk("R3 absolute jump skips", ram[8'h93], 0);
    chk("R3 relative jump skips", ram[8'h94], 0);

    // R9 R8: indirect with post-adjust, then absolute access
    newProg();
    ram[8'h40] = 16'h1111; ram[8'h41] = 16'h2222; ram[8'h42] = 16'h3333;
    ldi(1, 16'h40);
    emit(enc(12, 2, 1, 1));          // r2 = [0x40], r1 = 0x41
    emit(enc(12, 3, 1, 15));         // r3 = [0x41], r1 = 0x40
    emit(enc(13, 3, 1, 2));          // [0x40] = r3, r1 = 0x42
    sta(2, 16'h90); sta(3, 16'h91); sta(1, 16'h92);
    emit(enc(12, 1, 1, 1));          // d == a: load wins
    sta(1, 16'h93);
    emit(enc(14, 4, 0, 0)); emit(16'h0040);
    sta(4, 16'h94);
    endProg();
    ram[8'h40] = 16'h1111; ram[8'h41] = 16'h2222; ram[8'h42] = 16'h3333;
    runProg();
    chk("R9 load post-increment", ram[8'h90], 16'h1111);
    chk("R9 load post-decrement", ram[8'h91], 16'h2222);
    chk("R9 address register adjusted", ram[8'h92], 16'h0042);
    chk("R9 load wins over adjust", ram[8'h93], 16'h3333);
    chk("R9 indirect store landed", ram[8'h40], 16'h2222);
    chk("R8 absolute load", ram[8'h94], 16'h2222);

    // R7: memory operations leave flags alone
    newProg();
    emit(enc(1, 8, 0, 0));           // Z=1 C=1
    ldi(1, 16'h0005);
    emit(enc(12, 2, 9, 0));
    emit(enc(13, 1, 9, 0));
    sta(1, 16'h30);
    pred(14);
    pred(0); ldi(4, 1); pred(2); ldi(5, 1);
    sta(4, 16'hA0); sta(5, 16'hA1);
    endProg();
    runProg();
    chk("R7 Z kept through loads/stores", ram[8'hA0], 1);
    chk("R7 C kept through loads/stores", ram[8'hA1], 1);

    // R10: every condition against several flag patterns
    begin
      logic [15:0] pa [6], pb [6];
      pa = '{16'd5, 16'd3, 16'd5, 16'h8000, 16'h7FFF, 16'd0};
      pb = '{16'd5, 16'd5, 16'd3, 16'h0001, 16'hFFFF, 16'd1};
      foreach (pa[p]) begin
        logic [19:0] e;
        newProg();
        ldi(1, pa[p]); ldi(2, pb[p]); emit(enc(1, 3, 1, 2));
        for (int c = 0; c < 16; c++) begin
          ldi(4, 0); pred(c); ldi(4, 1); sta(4, 16'(16'hA0 + c));
        end
        endProg();
        runProg();
        e = model(1, pa[p], pb[p]);
        for (int c = 0; c < 16; c++)
          chk($sformatf("R10 condition %0d pattern %0d", c, p), ram[8'hA0 + c], condExp(c, e[19:16]));
      end
    end

    // R11: exactly one instruction squashed, jumps included
    newProg();
    emit(enc(1, 8, 0, 0));           // Z=1
    pred(1); ldi(4, 16'd5); ldi(5, 16'd6);
    pred(1); ldi(15, 16'h00F0); ldi(6, 16'd7);
    pred(0); emit(enc(4, 15, 15, 2)); ldi(7, 16'h0BAD);
    sta(4, 16'hA0); sta(5, 16'hA1); sta(6, 16'hA2); sta(7, 16'hA3);
    endProg();
    runProg();
    chk("R11 squashed load-immediate", ram[8'hA0], 0);
    chk("R11 next instruction runs", ram[8'hA1], 6);
    chk("R11 squashed jump not taken", ram[8'hA2], 7);
    chk("R11 predicated jump taken", ram[8'hA3], 0);

    // R12: strobe timing
    newProg();
    emit(enc(12, 1, 0, 0)); sta(1, 16'h96); endProg();
    runProg();
    chk("R12 load read strobe cycle", reCyc, 2);
    chk("R12 store after load cycle", weCyc, 7);
    newProg();
    emit(enc(0, 1, 0, 0)); sta(1, 16'h96); endProg();
    runProg();
    chk("R12 store after register op cycle", weCyc, 6);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule